// File: doc/BRIEF.md
# External Interrupt Port Controller

This block turns eight asynchronous, active-low interrupt pins and a separate non-maskable input into a single interrupt request for the processor core. The request carries an 8-bit vector number and a flag that marks the non-maskable case. The core presents its current priority. The block raises a request only when the winning source outranks that priority. The core acknowledges the request it is serving.

The eight pins can be used in three ways, chosen by a mode input:
- **Dedicated:** each pin is a separate source. Each pin has its own programmed vector and its own choice of low-level or falling-edge sensing.
- **Vector:** the whole port is read as one level-sensed vector number, taken in inverted form.
- **Split:** the upper three pins stay dedicated sources. The lower five pins give the upper bits of a vector whose low three bits are fixed.

The priority of any vector is its upper five bits. Tracing the vector table and switching context are left to the core.

Top module: `xirq_port`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it rises, `irq_req`, `irq_nmi` and `irq_vec` are all 0. Whenever `irq_req` is 0, `irq_vec` is 0 and `irq_nmi` is 0.
- R2: Mode is set by `port_mode`: 2'b00 dedicated, 2'b01 vector, 2'b10 split, 2'b11 port off.
  - In dedicated mode, a pin with `edge_sel[i]`=0 requests with vector `ded_vec[8*i+7:8*i]` for as long as the pin is low.
  - An acknowledge does not remove such a level request.
  - In mode 2'b11, the pins raise no request.
- R3: In dedicated mode, a pin with `edge_sel[i]`=1 latches a request on a falling edge. The request stays after the pin returns high, and an acknowledge of that source clears it.
- R4: In vector mode, the candidate vector is the bitwise inverse of the eight pins. It is always level-sensed, whatever `edge_sel` holds.
- R5: In split mode, pins 7..5 behave as dedicated sources. The port candidate is {~pin[4:0], 3'b010}.
- R6: A vector's priority is bits [7:3]. A request is raised only when that priority is strictly greater than `cur_pri`, so an equal priority raises nothing.
- R7: A vector value of 0, whether it is a programmed dedicated vector or the all-high port in vector mode, never raises a request.
- R8: Among the active dedicated sources, the highest priority wins, and a tie goes to the lower pin index. Between the dedicated winner and the port candidate, the higher priority wins, and a tie goes to the dedicated source.
- R9: A falling edge on `nmi_n` latches a non-maskable request.
  - This request overrides every other source and ignores `cur_pri`.
  - It presents `irq_req`=1, `irq_nmi`=1 and `irq_vec`=8'hF8.
  - An acknowledge clears it.
- R10: A pin change passes through a two-stage synchronizer. A level source changes the outputs at the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xin_n | input | 8 | Asynchronous active-low interrupt pins |
| nmi_n | input | 1 | Asynchronous active-low non-maskable input |
| port_mode | input | 2 | Pin usage mode (dedicated, vector, split, off) |
| edge_sel | input | 8 | Per pin: 1 falling edge, 0 low level (dedicated roles only) |
| ded_vec | input | 64 | Programmed vector for each pin, pin i at bits [8i+7:8i] |
| cur_pri | input | 5 | Current processor priority |
| ack | input | 1 | Core acknowledges the presented request |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector number of the presented request |
| irq_nmi | output | 1 | Presented request is the non-maskable one |

## Verification
The bench builds the block with its default parameters:
- eight pins and a five-bit priority;
- three dedicated pins in split mode, with a fill of 3'b010;
- a non-maskable vector of 8'hF8;
- two synchronizer stages.

With these values the vectors fit in a hand-written table. The split boundary sits between pins 5 and 4, and the tie rules between pins and against the port candidate can be reached with a few chosen pin patterns. A priority of 31 can hold off every ordinary source, which leaves the override by the non-maskable input as the only way a request can appear. Two synchronizer stages make the exact third-edge latency a fixed cycle that the bench can count.

// File: rtl/xirq_pkg.sv
// Shared definitions for the external interrupt port.
package xirq_pkg;

    // Port usage modes; the encoding is the value driven on port_mode.
    typedef enum logic [1:0] {
        XM_DEDICATED = 2'b00,
        XM_VECTOR    = 2'b01,
        XM_SPLIT     = 2'b10,
        XM_OFF       = 2'b11
    } xirq_mode_e;

endpackage

// File: rtl/xirq_sync.sv
// Multi-stage synchronizer for asynchronous active-low inputs.
// Assumes inputs idle high; every stage resets to 1 so no false edge follows reset.
module xirq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/xirq_edge.sv
// Falling-edge detector with per-bit pending latches.
// Assumes lvl_n is already synchronous. A bit latches on a 1->0 transition,
// is cleared by clr, and is forced to 0 while its arm bit is low.
// A new edge wins over a clear in the same cycle.
module xirq_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_n,
    input  logic [W-1:0] arm,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);

    logic [W-1:0] prev_n;
    logic [W-1:0] fall;

    // Detect high-to-low transitions of the synchronized level.
    always_comb begin
        fall = prev_n & ~lvl_n;
    end

    // Hold the previous level and update the pending latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_n <= '1;
            pend   <= '0;
        end else begin
            prev_n <= lvl_n;
            pend   <= ((pend & ~clr) | fall) & arm;
        end
    end

endmodule

// File: rtl/xirq_select.sv
// Picks the winning candidate among the dedicated sources and the port vector.
// Dedicated: highest priority wins, ties go to the lower pin index, zero vectors
// are skipped. The port candidate replaces the dedicated winner only with a
// strictly higher priority. Priority is the upper PRI_W bits of a vector.
module xirq_select #(
    parameter int PIN_W = 8,
    parameter int VEC_W = 8,
    parameter int PRI_W = 5,
    parameter int SRC_W = 4
) (
    input  logic [PIN_W-1:0]       ded_act,
    input  logic [PIN_W*VEC_W-1:0] ded_vec,
    input  logic                   port_act,
    input  logic [VEC_W-1:0]       port_vec,
    output logic                   win_valid,
    output logic [VEC_W-1:0]       win_vec,
    output logic [SRC_W-1:0]       win_src
);

    localparam int TOP = VEC_W - 1;
    localparam logic [SRC_W-1:0] PORT_ID = SRC_W'(PIN_W);

    logic [VEC_W-1:0] cv;

    // Scan the dedicated sources in index order, then weigh the port candidate.
    always_comb begin
        win_valid = 1'b0;
        win_vec   = '0;
        win_src   = '0;
        cv        = '0;
        for (int i = 0; i < PIN_W; i++) begin
            cv = ded_vec[i*VEC_W +: VEC_W];
            if (ded_act[i] && (cv != '0) &&
                (!win_valid || (cv[TOP -: PRI_W] > win_vec[TOP -: PRI_W]))) begin
                win_valid = 1'b1;
                win_vec   = cv;
                win_src   = SRC_W'(i);
            end
        end
        if (port_act &&
            (!win_valid || (port_vec[TOP -: PRI_W] > win_vec[TOP -: PRI_W]))) begin
            win_valid = 1'b1;
            win_vec   = port_vec;
            win_src   = PORT_ID;
        end
    end

endmodule

// File: rtl/xirq_port.sv
// External interrupt port controller.
// Converts the active-low pin port and the non-maskable input into one request
// with a vector number. Assumes pins are asynchronous, the core holds cur_pri
// steady while it reads a request, and ack is a one-cycle pulse issued while
// irq_req is high. Outputs are registered.
module xirq_port #(
    parameter int                      PIN_W       = 8,
    parameter int                      PRI_W       = 5,
    parameter int                      SPLIT_DED   = 3,
    parameter logic [SPLIT_DED-1:0]    SPLIT_FILL  = 3'b010,
    parameter logic [PIN_W-1:0]        NMI_VEC     = 8'hF8,
    parameter int                      SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PIN_W-1:0]       xin_n,
    input  logic                   nmi_n,
    input  logic [1:0]             port_mode,
    input  logic [PIN_W-1:0]       edge_sel,
    input  logic [PIN_W*PIN_W-1:0] ded_vec,
    input  logic [PRI_W-1:0]       cur_pri,
    input  logic                   ack,
    output logic                   irq_req,
    output logic [PIN_W-1:0]       irq_vec,
    output logic                   irq_nmi
);
    import xirq_pkg::*;

    localparam int VEC_W        = PIN_W;
    localparam int TOP          = VEC_W - 1;
    localparam int SPLIT_PORT_W = PIN_W - SPLIT_DED;
    localparam int SRC_W        = $clog2(PIN_W + 2);
    localparam logic [SRC_W-1:0] NMI_ID = SRC_W'(PIN_W + 1);

    xirq_mode_e         mode;
    logic [PIN_W:0]     s_all;
    logic [PIN_W-1:0]   s_pin;
    logic [0:0]         s_nmi;
    logic [PIN_W-1:0]   role;
    logic [PIN_W-1:0]   edge_pend;
    logic [PIN_W-1:0]   ded_act;
    logic [PIN_W-1:0]   ded_clr;
    logic [0:0]         nmi_pend;
    logic [0:0]         nmi_clr;
    logic               port_act;
    logic [VEC_W-1:0]   port_vec;
    logic               win_valid;
    logic [VEC_W-1:0]   win_vec;
    logic [SRC_W-1:0]   win_src;
    logic [SRC_W-1:0]   out_src;

    assign mode = xirq_mode_e'(port_mode);

    // Synchronize the port pins together with the non-maskable input.
    xirq_sync #(.W(PIN_W + 1), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({nmi_n, xin_n}),
        .q      (s_all)
    );

    assign s_pin = s_all[PIN_W-1:0];
    assign s_nmi = s_all[PIN_W];

    // Mark which pins act as dedicated sources in the current mode.
    always_comb begin
        case (mode)
            XM_DEDICATED: role = '1;
            XM_SPLIT:     role = {{SPLIT_DED{1'b1}}, {SPLIT_PORT_W{1'b0}}};
            default:      role = '0;
        endcase
    end

    // Edge latches for dedicated pins configured as falling-edge sources.
    xirq_edge #(.W(PIN_W)) u_pin_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl_n(s_pin),
        .arm  (role & edge_sel),
        .clr  (ded_clr),
        .pend (edge_pend)
    );

    // Edge latch for the non-maskable input.
    xirq_edge #(.W(1)) u_nmi_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl_n(s_nmi),
        .arm  (1'b1),
        .clr  (nmi_clr),
        .pend (nmi_pend)
    );

    // Combine level and edge sensing into the active dedicated sources.
    always_comb begin
        ded_act = role & ((edge_sel & edge_pend) | (~edge_sel & ~s_pin));
    end

    // Build the vector taken from the port in vector and split modes.
    always_comb begin
        case (mode)
            XM_VECTOR: port_vec = ~s_pin;
            XM_SPLIT:  port_vec = {~s_pin[SPLIT_PORT_W-1:0], SPLIT_FILL};
            default:   port_vec = '0;
        endcase
        port_act = (port_vec != '0);
    end

    // Choose the winning ordinary source.
    xirq_select #(
        .PIN_W(PIN_W),
        .VEC_W(VEC_W),
        .PRI_W(PRI_W),
        .SRC_W(SRC_W)
    ) u_select (
        .ded_act  (ded_act),
        .ded_vec  (ded_vec),
        .port_act (port_act),
        .port_vec (port_vec),
        .win_valid(win_valid),
        .win_vec  (win_vec),
        .win_src  (win_src)
    );

    // Decode the acknowledge into a clear for the source being presented.
    always_comb begin
        ded_clr = '0;
        nmi_clr = 1'b0;
        if (ack && irq_req) begin
            if (irq_nmi) begin
                nmi_clr = 1'b1;
            end else if (out_src < SRC_W'(PIN_W)) begin
                ded_clr = PIN_W'(1) << out_src;
            end
        end
    end

    // Register the request, giving the non-maskable source absolute precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_nmi <= 1'b0;
            irq_vec <= '0;
            out_src <= '0;
        end else if (nmi_pend[0]) begin
            irq_req <= 1'b1;
            irq_nmi <= 1'b1;
            irq_vec <= NMI_VEC;
            out_src <= NMI_ID;
        end else if (win_valid && (win_vec[TOP -: PRI_W] > cur_pri)) begin
            irq_req <= 1'b1;
            irq_nmi <= 1'b0;
            irq_vec <= win_vec;
            out_src <= win_src;
        end else begin
            irq_req <= 1'b0;
            irq_nmi <= 1'b0;
            irq_vec <= '0;
            out_src <= '0;
        end
    end

endmodule

// File: rtl/xirq_chk.sv
// Protocol checks on the interrupt port outputs, bound to xirq_port.
module xirq_chk #(
    parameter int               PIN_W   = 8,
    parameter int               PRI_W   = 5,
    parameter logic [PIN_W-1:0] NMI_VEC = 8'hF8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PRI_W-1:0] cur_pri,
    input logic             irq_req,
    input logic [PIN_W-1:0] irq_vec,
    input logic             irq_nmi
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!irq_req && !irq_nmi)); // R1

    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vec == '0 && !irq_nmi)); // R1

    AST_ABOVE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_nmi) |-> (irq_vec[PIN_W-1 -: PRI_W] > $past(cur_pri))); // R6

    AST_VECTOR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec != '0)); // R7

    AST_NMI_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nmi |-> irq_req); // R9

    AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nmi |-> (irq_vec == NMI_VEC)); // R9

endmodule

bind xirq_port xirq_chk #(
    .PIN_W  (PIN_W),
    .PRI_W  (PRI_W),
    .NMI_VEC(NMI_VEC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_pri(cur_pri),
    .irq_req(irq_req),
    .irq_vec(irq_vec),
    .irq_nmi(irq_nmi)
);

// File: tb/sim_xirq_port.sv
// Bench for xirq_port: a vector table walk followed by directed tests.
module sim_xirq_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  xin_n = 8'hFF;
    logic        nmi_n = 1'b1;
    logic [1:0]  port_mode = 2'b00;
    logic [7:0]  edge_sel = 8'h00;
    logic [63:0] ded_vec = {8'h13, 8'hA2, 8'h31, 8'h80, 8'h00, 8'h4A, 8'h49, 8'h21};
    logic [4:0]  cur_pri = 5'd0;
    logic        ack = 1'b0;
    logic        irq_req;
    logic [7:0]  irq_vec;
    logic        irq_nmi;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    xirq_port u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .xin_n    (xin_n),
        .nmi_n    (nmi_n),
        .port_mode(port_mode),
        .edge_sel (edge_sel),
        .ded_vec  (ded_vec),
        .cur_pri  (cur_pri),
        .ack      (ack),
        .irq_req  (irq_req),
        .irq_vec  (irq_vec),
        .irq_nmi  (irq_nmi)
    );

    // Row layout: mode[23:22] pins[21:14] cur_pri[13:9] exp_req[8] exp_vec[7:0]
    localparam int NROW = 16;
    localparam logic [23:0] ROWS [NROW] = '{
        {2'b00, 8'hFE, 5'd0,  1'b1, 8'h21},  // R2 level pin0
        {2'b00, 8'hFE, 5'd4,  1'b0, 8'h00},  // R6 equal priority
        {2'b00, 8'hFE, 5'd3,  1'b1, 8'h21},  // R6 one below
        {2'b00, 8'hF9, 5'd0,  1'b1, 8'h49},  // R8 tie, lower pin
        {2'b00, 8'hF7, 5'd0,  1'b0, 8'h00},  // R7 zero dedicated vector
        {2'b00, 8'hAE, 5'd0,  1'b1, 8'hA2},  // R8 highest priority pin
        {2'b01, 8'hFF, 5'd0,  1'b0, 8'h00},  // R7 idle port in vector mode
        {2'b01, 8'h3C, 5'd0,  1'b1, 8'hC3},  // R4 inverted port
        {2'b01, 8'h3C, 5'd24, 1'b0, 8'h00},  // R6 equal priority
        {2'b01, 8'h3C, 5'd23, 1'b1, 8'hC3},  // R4 above priority
        {2'b10, 8'hF0, 5'd0,  1'b1, 8'h7A},  // R5 fill bits
        {2'b10, 8'h7F, 5'd0,  1'b1, 8'h13},  // R5 pin7 dedicated
        {2'b10, 8'hBF, 5'd0,  1'b1, 8'hA2},  // R5 pin6 dedicated
        {2'b10, 8'hA0, 5'd0,  1'b1, 8'hFA},  // R8 port beats pin6
        {2'b11, 8'h00, 5'd0,  1'b0, 8'h00},  // R2 port off
        {2'b00, 8'hFF, 5'd0,  1'b0, 8'h00}   // R2 all idle
    };
    localparam string TAGS [NROW] = '{"R2", "R6", "R6", "R8", "R7", "R8", "R7", "R4",
                                      "R6", "R4", "R5", "R5", "R5", "R8", "R2", "R2"};

    // Compare {req, nmi, vec} with the expected value and count the result.
    task automatic check(input string tag, input logic [9:0] exp);
        logic [9:0] act;
        act = {irq_req, irq_nmi, irq_vec};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One-cycle acknowledge pulse, driven between clock edges.
    task automatic pulse_ack();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 held in reset", 10'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 10'h000);

        // Table walk over modes, priorities and pin patterns.
        for (int i = 0; i < NROW; i++) begin
            port_mode = ROWS[i][23:22];
            xin_n     = ROWS[i][21:14];
            cur_pri   = ROWS[i][13:9];
            repeat (6) @(negedge clk);
            check(TAGS[i], {ROWS[i][8], 1'b0, ROWS[i][7:0]});
        end

        // R10: synchronizer latency on a level source.
        port_mode = 2'b00; edge_sel = 8'h00; cur_pri = 5'd0; xin_n = 8'hFF;
        repeat (6) @(negedge clk);
        xin_n = 8'hFE;
        @(negedge clk);
        check("R10 one edge", 10'h000);
        @(negedge clk);
        check("R10 two edges", 10'h000);
        @(negedge clk);
        check("R10 three edges", {2'b10, 8'h21});

        // R2: an acknowledge does not remove a level request.
        repeat (3) @(negedge clk);
        pulse_ack();
        repeat (4) @(negedge clk);
        check("R2 level survives ack", {2'b10, 8'h21});
        xin_n = 8'hFF;
        repeat (5) @(negedge clk);
        check("R2 level released", 10'h000);

        // R3: falling-edge latch on pin4, held after release, cleared by ack.
        edge_sel = 8'h10;
        repeat (4) @(negedge clk);
        xin_n = 8'hEF;
        repeat (2) @(negedge clk);
        xin_n = 8'hFF;
        repeat (6) @(negedge clk);
        check("R3 edge latched", {2'b10, 8'h80});
        pulse_ack();
        repeat (3) @(negedge clk);
        check("R3 edge cleared by ack", 10'h000);

        // R4: vector mode ignores edge_sel and stays level sensed.
        port_mode = 2'b01; edge_sel = 8'hFF; xin_n = 8'h3C;
        repeat (6) @(negedge clk);
        check("R4 vector with edge_sel set", {2'b10, 8'hC3});
        xin_n = 8'hFF;
        repeat (6) @(negedge clk);
        check("R4 no latch after release", 10'h000);

        // R9: non-maskable input overrides the priority mask and other sources.
        port_mode = 2'b00; edge_sel = 8'h00; cur_pri = 5'd31; xin_n = 8'hBF;
        repeat (6) @(negedge clk);
        check("R6 pin6 masked by priority", 10'h000);
        nmi_n = 1'b0;
        repeat (2) @(negedge clk);
        nmi_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 nmi over priority 31", {2'b11, 8'hF8});
        cur_pri = 5'd0;
        repeat (3) @(negedge clk);
        check("R9 nmi over pin6", {2'b11, 8'hF8});
        pulse_ack();
        repeat (3) @(negedge clk);
        check("R9 nmi cleared, pin6 shown", {2'b10, 8'hA2});

        // R1: reset while a request is active.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset drops request", 10'h000);
        xin_n = 8'hFF;
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 quiet after reset", 10'h000);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule